// File: doc/BRIEF.md
# Serial Configuration Bitstream Streamer

This block models a serial memory that streams a fixed configuration image, one bit per data-clock period, into an SRAM-based programmable device. The image is a parameter of width `DEPTH`. An address counter walks it from bit 0 upward. The current bit appears on `data_o`. A tri-state pin is modelled by the pair `data_o` / `data_en_o`, and `data_en_o` low means the pin floats.

Several instances can be chained. While `oe_i` is low, or while the power-on delay is still running, the block records its chain position from `cs_n_i`:
- With `cs_n_i` low it becomes the head of the chain. It then generates the data clock itself on `dclk_o`.
- With `cs_n_i` high it becomes a follower. It then steps on falling edges of `ext_dclk_i`, and only while its own chip select is low.

When the whole image has been sent, `casc_n_o` drops. It is normally wired to the next instance's chip select, which hands the stream over to that instance. The address advances on the falling edge of the data clock, so each bit is stable across the following rising edge, where the receiver samples it.

Driving `oe_i` low restarts the stream. The power-on delay of `POR_CYCLES` system clocks is applied only once, after `rst_n` is released.

Top module: `cfg_bit_streamer`

## Requirements
- R1: While `rst_n` is low, `data_en_o` is 0, `casc_n_o` is 1 and `dclk_o` is 0.
- R2: For `POR_CYCLES` clock cycles after `rst_n` rises, `data_en_o` and `dclk_o` stay 0 whatever `oe_i` and `cs_n_i` do.
- R3: Chain position is sampled from `cs_n_i` on every clock edge where `oe_i` is low or the power-on delay is running. The value is held once `oe_i` is high. Position follower (`cs_n_i` was 1) never drives `dclk_o` high.
- R4: Position head, with `oe_i` high and `cs_n_i` low: `dclk_o` toggles every `HALF_PERIOD` clock cycles, so its period is 2×`HALF_PERIOD` cycles.
- R5: Bits leave from address 0 upward. At address i, `data_o` equals `INIT_BITS[i]`. The address advances by one per falling edge of the active data clock (`dclk_o` for the head, `ext_dclk_i` for a follower).
- R6: A follower advances only on falling edges of `ext_dclk_i` seen while `cs_n_i` is low. Edges seen while `cs_n_i` is high leave the address unchanged.
- R7: `data_en_o` is 0 whenever `oe_i` is 0, `cs_n_i` is 1, or all `DEPTH` bits have been sent. While `data_en_o` is 0, `data_o` is 0.
- R8: Once `DEPTH` bits have been sent, `casc_n_o` goes to 0 and stays 0 while `oe_i` is high. Further data-clock edges do not move the address.
- R9: One clock edge with `oe_i` low returns the address to 0 and `casc_n_o` to 1. A restart after that edge does not repeat the power-on delay: the head's first `dclk_o` rise follows within `HALF_PERIOD`+2 cycles.
- R10: The head keeps toggling `dclk_o` after its image ends, while `oe_i` is high and `cs_n_i` is low, so that later devices in the chain still receive a clock.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous power-on reset, active low |
| oe_i | input | 1 | Output enable; low restarts the stream |
| cs_n_i | input | 1 | Chip select, active low |
| ext_dclk_i | input | 1 | Data clock from the chain head (used by followers) |
| dclk_o | output | 1 | Generated data clock (head only) |
| data_o | output | 1 | Serial configuration bit |
| data_en_o | output | 1 | Drive enable for `data_o` (0 = high impedance) |
| casc_n_o | output | 1 | Cascade select, low once the image is exhausted |

## Verification
The assertions assume the following about the inputs:
- `ext_dclk_i` is a level that changes at most once per system clock, so a falling edge is never missed or double-counted.
- `oe_i` and `cs_n_i` are synchronous to `clk`.

The stimulus meets these assumptions. It changes every input only on the falling edge of `clk`, and it holds `ext_dclk_i` at each level for a full cycle.

The stimulus also controls chain position. It selects the position by holding `cs_n_i` at a known level during every cycle in which `oe_i` is low. It never lowers `oe_i` while `cs_n_i` is at a level that would pick an unintended position.

// File: rtl/cfg_stream_pkg.sv
package cfg_stream_pkg;
   typedef enum logic {
      POS_FOLLOW = 1'b0,
      POS_HEAD   = 1'b1
   } chain_pos_e;
endpackage

// File: rtl/cfg_por_timer.sv
module cfg_por_timer #(
   parameter int POR_CYCLES = 20
) (
   input  logic clk,
   input  logic rst_n,
   output logic done_o
);
   localparam int CNT_W = (POR_CYCLES > 1) ? $clog2(POR_CYCLES) : 1;
   localparam logic [CNT_W-1:0] LAST = CNT_W'(POR_CYCLES - 1);

   logic [CNT_W-1:0] cnt_q;
   logic             done_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q  <= '0;
         done_q <= 1'b0;
      end else if (!done_q) begin
         if (cnt_q == LAST) begin
            done_q <= 1'b1;
         end else begin
            cnt_q <= cnt_q + 1'b1;
         end
      end
   end

   assign done_o = done_q;
endmodule

// File: rtl/cfg_dclk_gen.sv
module cfg_dclk_gen #(
   parameter int HALF_PERIOD = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic en_i,
   output logic dclk_o,
   output logic fall_o
);
   logic dclk_q;
   logic last_tick;

   generate
      if (HALF_PERIOD == 1) begin : g_toggle
         assign last_tick = 1'b1;
      end else begin : g_divide
         localparam int DIV_W = $clog2(HALF_PERIOD);
         localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(HALF_PERIOD - 1);
         logic [DIV_W-1:0] div_q;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               div_q <= '0;
            end else if (!en_i || div_q == DIV_LAST) begin
               div_q <= '0;
            end else begin
               div_q <= div_q + 1'b1;
            end
         end

         assign last_tick = (div_q == DIV_LAST);
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         dclk_q <= 1'b0;
      end else if (!en_i) begin
         dclk_q <= 1'b0;
      end else if (last_tick) begin
         dclk_q <= ~dclk_q;
      end
   end

   assign dclk_o = dclk_q;
   assign fall_o = en_i & last_tick & dclk_q;
endmodule

// File: rtl/cfg_addr_ctr.sv
module cfg_addr_ctr #(
   parameter int DEPTH  = 32,
   parameter int ADDR_W = $clog2(DEPTH + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clr_i,
   input  logic              step_i,
   output logic [ADDR_W-1:0] addr_o,
   output logic              end_o
);
   localparam logic [ADDR_W-1:0] LIMIT = ADDR_W'(DEPTH);

   logic [ADDR_W-1:0] addr_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         addr_q <= '0;
      end else if (clr_i) begin
         addr_q <= '0;
      end else if (step_i && addr_q != LIMIT) begin
         addr_q <= addr_q + 1'b1;
      end
   end

   assign addr_o = addr_q;
   assign end_o  = (addr_q == LIMIT);
endmodule

// File: rtl/cfg_bit_streamer.sv
module cfg_bit_streamer
   import cfg_stream_pkg::*;
#(
   parameter int               DEPTH       = 32,
   parameter logic [DEPTH-1:0] INIT_BITS   = '0,
   parameter int               POR_CYCLES  = 20,
   parameter int               HALF_PERIOD = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic oe_i,
   input  logic cs_n_i,
   input  logic ext_dclk_i,
   output logic dclk_o,
   output logic data_o,
   output logic data_en_o,
   output logic casc_n_o
);
   localparam int ADDR_W = $clog2(DEPTH + 1);
   localparam int IDX_W  = $clog2(DEPTH);

   generate
      if (DEPTH < 2) begin : g_bad_depth
         $error("cfg_bit_streamer: DEPTH must be at least 2");
      end
      if (POR_CYCLES < 1) begin : g_bad_por
         $error("cfg_bit_streamer: POR_CYCLES must be at least 1");
      end
      if (HALF_PERIOD < 1) begin : g_bad_half
         $error("cfg_bit_streamer: HALF_PERIOD must be at least 1");
      end
   endgenerate

   logic              por_done;
   chain_pos_e        pos_q;
   logic              pos_first;
   logic              ext_prev_q;
   logic              ext_fall;
   logic              sel_active;
   logic              osc_en;
   logic              osc_fall;
   logic              step;
   logic              at_end;
   logic [ADDR_W-1:0] addr_q;
   logic              rom_bit;

   cfg_por_timer #(.POR_CYCLES(POR_CYCLES)) u_por (
      .clk    (clk),
      .rst_n  (rst_n),
      .done_o (por_done)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pos_q      <= POS_FOLLOW;
         ext_prev_q <= 1'b1;
      end else begin
         ext_prev_q <= ext_dclk_i;
         if (!oe_i || !por_done) begin
            pos_q <= cs_n_i ? POS_FOLLOW : POS_HEAD;
         end
      end
   end

   assign pos_first  = (pos_q == POS_HEAD);
   assign ext_fall   = ext_prev_q & ~ext_dclk_i;
   assign sel_active = por_done & oe_i & ~cs_n_i;
   assign osc_en     = sel_active & pos_first;

   cfg_dclk_gen #(.HALF_PERIOD(HALF_PERIOD)) u_osc (
      .clk    (clk),
      .rst_n  (rst_n),
      .en_i   (osc_en),
      .dclk_o (dclk_o),
      .fall_o (osc_fall)
   );

   assign step = sel_active & (pos_first ? osc_fall : ext_fall);

   cfg_addr_ctr #(.DEPTH(DEPTH), .ADDR_W(ADDR_W)) u_addr (
      .clk    (clk),
      .rst_n  (rst_n),
      .clr_i  (~oe_i),
      .step_i (step),
      .addr_o (addr_q),
      .end_o  (at_end)
   );

   assign rom_bit   = INIT_BITS[addr_q[IDX_W-1:0]];
   assign data_en_o = sel_active & ~at_end;
   assign data_o    = data_en_o & rom_bit;
   assign casc_n_o  = ~at_end;
endmodule

// File: rtl/cfg_bit_streamer_chk.sv
module cfg_bit_streamer_chk #(
   parameter int ADDR_W = 6
) (
   input logic              clk,
   input logic              rst_n,
   input logic              oe_i,
   input logic              cs_n_i,
   input logic              dclk_o,
   input logic              data_en_o,
   input logic              casc_n_o,
   input logic              por_done,
   input logic              pos_first,
   input logic [ADDR_W-1:0] addr
);
   always_comb begin
      if (!rst_n) begin
         a_reset_quiet_r1 : assert (!data_en_o && casc_n_o && !dclk_o);
      end
   end

   p_quiet_before_por_r2 : assert property (@(posedge clk) disable iff (!rst_n)
      !por_done |-> (!data_en_o && !dclk_o));

   p_follower_no_clk_r3 : assert property (@(posedge clk) disable iff (!rst_n)
      !pos_first |-> !dclk_o);

   p_addr_single_step_r5 : assert property (@(posedge clk) disable iff (!rst_n)
      oe_i |=> (addr == $past(addr) || addr == $past(addr) + 1'b1));

   p_hold_deselected_r6 : assert property (@(posedge clk) disable iff (!rst_n)
      (oe_i && cs_n_i) |=> (addr == $past(addr)));

   p_float_gate_r7 : assert property (@(posedge clk) disable iff (!rst_n)
      (!oe_i || cs_n_i) |-> !data_en_o);

   p_casc_sticky_r8 : assert property (@(posedge clk) disable iff (!rst_n)
      (!casc_n_o && oe_i) |=> !casc_n_o);

   p_end_floats_r8 : assert property (@(posedge clk) disable iff (!rst_n)
      !casc_n_o |-> !data_en_o);

   p_restart_clears_r9 : assert property (@(posedge clk) disable iff (!rst_n)
      !oe_i |=> (casc_n_o && addr == '0));
endmodule

bind cfg_bit_streamer cfg_bit_streamer_chk #(.ADDR_W(ADDR_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .oe_i      (oe_i),
   .cs_n_i    (cs_n_i),
   .dclk_o    (dclk_o),
   .data_en_o (data_en_o),
   .casc_n_o  (casc_n_o),
   .por_done  (por_done),
   .pos_first (pos_first),
   .addr      (addr_q)
);

// File: tb/cfg_bit_streamer_tb.sv
module cfg_bit_streamer_tb_top;
   localparam int          CLK_PERIOD = 10;
   localparam int          DEPTH      = 32;
   localparam logic [31:0] BITS       = 32'hA5C3_1E96;
   localparam int          POR        = 20;
   localparam int          HALF       = 2;
   localparam int          NROWS      = 14;
   // row = {oe, cs_n, ext, exp_en, exp_data, exp_casc_n}
   localparam logic [5:0] TBL [NROWS] = '{
      6'b111001, 6'b101101, 6'b100111, 6'b101111, 6'b100111,
      6'b111001, 6'b110001, 6'b101111, 6'b100101, 6'b101101,
      6'b100111, 6'b011001, 6'b101101, 6'b100111
   };

   logic clk = 1'b0;
   logic rst_n, oe, cs_n, ext;
   logic dclk, data, data_en, casc_n;
   int   checks = 0;
   int   failures = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   cfg_bit_streamer #(
      .DEPTH(DEPTH), .INIT_BITS(BITS), .POR_CYCLES(POR), .HALF_PERIOD(HALF)
   ) dut_i (
      .clk(clk), .rst_n(rst_n), .oe_i(oe), .cs_n_i(cs_n), .ext_dclk_i(ext),
      .dclk_o(dclk), .data_o(data), .data_en_o(data_en), .casc_n_o(casc_n)
   );

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic step();
      @(posedge clk);
      @(negedge clk);
   endtask

   task automatic finish_run();
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      failures++;
      $display("FAIL watchdog (all requirements) actual=timeout expected=done");
      finish_run();
   end

   initial begin
      int bad;
      int k;
      int cyc;
      int first_rise;
      int last_rise;
      int after_end;
      int per_bad;
      logic prev;

      rst_n = 1'b0; oe = 1'b0; cs_n = 1'b1; ext = 1'b1;
      repeat (3) @(negedge clk);
      // R1 reset state
      chk(!data_en && casc_n && !dclk, "R1 reset outputs",
          {data_en, casc_n, dclk}, 3'b010);

      // R2 power-on delay: selected and enabled, yet silent
      rst_n = 1'b1; oe = 1'b1; cs_n = 1'b0;
      bad = 0;
      for (int i = 0; i < POR - 4; i++) begin
         step();
         if (data_en || dclk) bad++;
      end
      chk(bad == 0, "R2 silent during power-on delay", bad, 0);

      // select follower position (R3)
      oe = 1'b0; cs_n = 1'b1;
      repeat (8) step();

      // table walk: follower stepping, deselect, restart (R3 R5 R6 R7 R9)
      for (int i = 0; i < NROWS; i++) begin
         logic [5:0] r;
         r = TBL[i];
         oe = r[5]; cs_n = r[4]; ext = r[3];
         step();
         chk(data_en == r[2], $sformatf("R7 table row %0d enable", i), data_en, r[2]);
         if (r[2]) chk(data == r[1], $sformatf("R5/R6 table row %0d data", i), data, r[1]);
         chk(casc_n == r[0], $sformatf("R9 table row %0d casc", i), casc_n, r[0]);
         chk(!dclk, $sformatf("R3 table row %0d follower clock", i), dclk, 0);
      end

      // follower runs to the end of the image (R5 R8)
      bad = 0;
      for (int j = 1; j < DEPTH; j++) begin
         ext = 1'b1; step();
         if (!(data_en && data == BITS[j])) bad++;
         ext = 1'b0; step();
      end
      chk(bad == 0, "R5 follower stream bits", bad, 0);
      chk(!casc_n, "R8 cascade low at end", casc_n, 0);
      chk(!data_en, "R7 float after end", data_en, 0);
      ext = 1'b1; step(); ext = 1'b0; step();
      chk(!casc_n && !data_en, "R8 extra edge ignored at end", {casc_n, data_en}, 0);
      oe = 1'b0; step();
      chk(casc_n, "R9 restart returns cascade high", casc_n, 1);

      // head position: own clock, full image, clock continues (R4 R5 R9 R10)
      ext = 1'b1; cs_n = 1'b0; step();
      oe = 1'b1;
      k = 0; cyc = 0; first_rise = -1; last_rise = 0; after_end = 0; per_bad = 0; bad = 0;
      prev = 1'b0;
      for (int i = 0; i < 600; i++) begin
         step();
         cyc++;
         if (dclk && !prev) begin
            if (first_rise < 0) first_rise = cyc;
            else if (cyc - last_rise != 2 * HALF) per_bad++;
            last_rise = cyc;
            if (data_en) begin
               if (k >= DEPTH || data != BITS[k]) bad++;
               k++;
            end else begin
               after_end++;
            end
         end
         prev = dclk;
         if (after_end >= 2) break;
      end
      chk(first_rise > 0 && first_rise <= HALF + 2, "R9 no power-on delay on restart",
          first_rise, HALF + 2);
      chk(per_bad == 0, "R4 head clock period", per_bad, 0);
      chk(bad == 0, "R5 head stream bits", bad, 0);
      chk(k == DEPTH, "R5 head bit count", k, DEPTH);
      chk(!casc_n && !data_en, "R8 head end state", {casc_n, data_en}, 0);
      chk(after_end >= 2, "R10 clock continues after end", after_end, 2);

      cs_n = 1'b1; oe = 1'b0; step();
      chk(casc_n && !dclk, "R9 reset after head run", {casc_n, dclk}, 2'b10);

      finish_run();
   end
endmodule